// File: doc/BRIEF.md
# Serial-Loaded Converter Code Port with Chain Output

This block is the digital front end of a 12-bit converter that is loaded over a three-wire serial link. A host lowers an active-low frame signal, clocks a 16-bit word in most significant bit first, and raises the frame signal again. The rising edge of the frame signal ends the frame. At that point the two leading command bits of the word decide what happens: the converter code is loaded, the chain output is turned off, the frame is ignored, or the capture edge of the serial clock moves to the rising edge.

The serial link is sampled by a system clock that runs at least four times faster than the serial clock. All three link inputs pass through a two-stage synchroniser, and serial-clock edges are detected in the system-clock domain. Bits that leave the 16-bit shift register are driven onto a serial output on the edge opposite to the capture edge. Several devices can therefore be chained, with the frame lasting 16 clocks per device.

A three-state controller sequences each frame:
- `ST_IDLE` waits for the frame signal to go low and then moves to `ST_SHIFT`, with the edge count cleared.
- `ST_SHIFT` counts and shifts bits on capture edges. When the frame signal goes high it moves to `ST_APPLY`.
- `ST_APPLY` lasts one cycle. It acts on the command if at least 16 capture edges were seen, then returns to `ST_IDLE`.

Top module: `chain_dac_port`

## Requirements
- R1: After reset, `dac_code` is 0, `dac_upd` is 0, `ser_out` is 0, `rise_mode` is 0 (capture on the falling edge of `ser_clk`) and `sdo_en` is 1.
- R2: The frame is shifted in most significant bit first. Bits 15:14 of the last 16 captured bits are the command, bits 13:2 are the code and bits 1:0 are ignored. Command 00 copies bits 13:2 into `dac_code` when the frame ends.
- R3: `dac_upd` is high for exactly one system-clock cycle for every write of `dac_code`, and `dac_code` never changes without it.
- R4: `dac_code` does not change while `frame_n` is low. It is written only after `frame_n` rises.
- R5: A frame that ends after fewer than 16 capture edges changes neither `dac_code` nor any mode output.
- R6: Command 10 is a no-operation: `dac_code`, `rise_mode` and `sdo_en` keep their values.
- R7: Command 11 sets `rise_mode`, so later frames capture on the rising edge of `ser_clk`. That frame does not write `dac_code`. Only reset clears `rise_mode`.
- R8: Command 01 clears `sdo_en`. From then on `ser_out` stays low until reset.
- R9: While `frame_n` is low, each non-capture edge of `ser_clk` drives the oldest bit of the shift register onto `ser_out`. A bit therefore reappears 16 clocks after it entered, and a 32-clock frame leaves the device holding the last 16 bits.
- R10: Edges of `ser_clk` while `frame_n` is high change neither the shift register, nor `ser_out`, nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| frame_n | input | 1 | Active-low frame signal |
| ser_clk | input | 1 | Serial clock |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Chain data out, next device's input |
| dac_code | output | 12 | Converter code register |
| dac_upd | output | 1 | One-cycle pulse on each code write |
| rise_mode | output | 1 | 1 when capture is on the rising serial edge |
| sdo_en | output | 1 | 1 while the chain output is enabled |

## Verification
Each fault class shows at the ports within a known time:
- A shift register that slips or drops a bit shows up on `ser_out`, with the wrong bit 16 serial clocks after the bad capture. It also shows up in the code loaded at the end of the frame.
- A faulty edge-select or output-enable state shows one frame later: the chain output has the wrong polarity of update edge or fails to stay low, and the next load brings in a code shifted by a bit.
- A miscounted frame length or a broken command decode shows a few system clocks after `frame_n` rises. `dac_code`, `dac_upd` and the mode outputs are compared against a bench model on every clock outside that short settling window.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        CMD_LOAD    = 2'b00,
        CMD_SDO_OFF = 2'b01,
        CMD_NOP     = 2'b10,
        CMD_RISE    = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } state_e;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic rise_sel,
    output logic cap_ev,
    output logic out_ev
);

    logic prev;
    logic up_ev;
    logic dn_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= sclk_s;
        end
    end

    assign up_ev  = sclk_s & ~prev;
    assign dn_ev  = ~sclk_s & prev;
    assign cap_ev = rise_sel ? up_ev : dn_ev;
    assign out_ev = rise_sel ? dn_ev : up_ev;

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               cap_ev,
    input  logic               out_ev,
    input  logic               bit_in,
    input  logic               out_on,
    output logic [FRAME_W-1:0] word,
    output logic               full,
    output logic               bit_out
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && cap_ev) begin
            word <= {word[FRAME_W-2:0], bit_in};
            if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
        end else if (!out_on) begin
            bit_out <= 1'b0;
        end else if (en && out_ev) begin
            bit_out <= word[FRAME_W-1];
        end
    end

    assign full = (cnt == CNT_MAX);

endmodule

// File: rtl/chain_dac_port.sv
module chain_dac_port
    import sdac_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int CMD_W       = 2,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frame_n,
    input  logic                             ser_clk,
    input  logic                             ser_in,
    output logic                             ser_out,
    output logic [FRAME_W-CMD_W-PAD_W-1:0]   dac_code,
    output logic                             dac_upd,
    output logic                             rise_mode,
    output logic                             sdo_en
);

    localparam int CODE_W  = FRAME_W - CMD_W - PAD_W;
    localparam int CODE_HI = FRAME_W - CMD_W - 1;

    state_e             state;
    state_e             state_nx;
    logic [2:0]         pins_s;
    logic               fs_s;
    logic               sclk_s;
    logic               din_s;
    logic               cap_ev;
    logic               out_ev;
    logic [FRAME_W-1:0] word;
    logic               full;
    logic               shift_en;
    cmd_e               cmd;

    sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({frame_n, ser_clk, ser_in}),
        .q     (pins_s)
    );

    assign fs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign din_s  = pins_s[0];

    sdac_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .rise_sel (rise_mode),
        .cap_ev   (cap_ev),
        .out_ev   (out_ev)
    );

    assign shift_en = (state == ST_SHIFT) && !fs_s;

    sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE),
        .en      (shift_en),
        .cap_ev  (cap_ev),
        .out_ev  (out_ev),
        .bit_in  (din_s),
        .out_on  (sdo_en),
        .word    (word),
        .full    (full),
        .bit_out (ser_out)
    );

    assign cmd = cmd_e'(word[FRAME_W-1 -: CMD_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!fs_s) state_nx = ST_SHIFT;
            ST_SHIFT: if (fs_s)  state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_code  <= '0;
            dac_upd   <= 1'b0;
            rise_mode <= 1'b0;
            sdo_en    <= 1'b1;
        end else begin
            dac_upd <= 1'b0;
            if (state == ST_APPLY && full) begin
                unique case (cmd)
                    CMD_LOAD: begin
                        dac_code <= word[CODE_HI -: CODE_W];
                        dac_upd  <= 1'b1;
                    end
                    CMD_SDO_OFF: sdo_en    <= 1'b0;
                    CMD_NOP:     ;
                    CMD_RISE:    rise_mode <= 1'b1;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdac_chk.sv
module sdac_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              ser_out,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_upd,
    input logic              rise_mode,
    input logic              sdo_en
);

    // R3
    upd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |=> !dac_upd);

    // R3
    code_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> dac_upd);

    // R4
    upd_frame_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |-> frame_n);

    // R8
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdo_en && !$rose(sdo_en)) |=> !ser_out);

    // R8
    sdo_off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |=> !sdo_en);

    // R7
    rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_mode |=> rise_mode);

endmodule

bind chain_dac_port sdac_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .ser_out   (ser_out),
    .dac_code  (dac_code),
    .dac_upd   (dac_upd),
    .rise_mode (rise_mode),
    .sdo_en    (sdo_en)
);

// File: tb/chain_dac_port_tb.sv
module chain_dac_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic [11:0] dac_code;
    logic        dac_upd;
    logic        rise_mode;
    logic        sdo_en;

    int checks = 0;
    int failures = 0;
    int upd_seen = 0;
    int m_upd = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    logic [15:0] m_sr;
    logic [11:0] m_dac;
    logic        m_rise;
    logic        m_en;
    logic        m_sdo;
    int          m_cnt;

    always #4 clk = ~clk;

    chain_dac_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .ser_clk   (ser_clk),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .dac_code  (dac_code),
        .dac_upd   (dac_upd),
        .rise_mode (rise_mode),
        .sdo_en    (sdo_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R2 R4 R6 R7 R8 R3)
    always @(negedge clk) begin
        if (rst_n && dac_upd) upd_seen++;
        if (rst_n && cmp_on) begin
            chk(dac_code == m_dac, "R4 dac_code", int'(dac_code), int'(m_dac));
            chk(rise_mode == m_rise, "R7 rise_mode", int'(rise_mode), int'(m_rise));
            chk(sdo_en == m_en, "R8 sdo_en", int'(sdo_en), int'(m_en));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R9 R10: ser_out is checked before every serial clock edge
    task automatic toggle_sclk();
        chk(ser_out == m_sdo, "R9 ser_out", int'(ser_out), int'(m_sdo));
        ser_clk = ~ser_clk;
        if (!frame_n) begin
            if (ser_clk == m_rise) begin
                m_sr = {m_sr[14:0], ser_in};
                m_cnt++;
            end else begin
                m_sdo = m_en ? m_sr[15] : 1'b0;
            end
        end
        wait_clk(8);
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        frame_n = 1'b0;
        m_cnt = 0;
        wait_clk(8);
        for (int i = 0; i < n; i++) begin
            ser_in = bits[n-1-i];
            wait_clk(4);
            toggle_sclk();
            toggle_sclk();
        end
        // R4: nothing written yet while the frame is open
        chk(upd_seen == m_upd, "R4 no write in frame", upd_seen, m_upd);
        cmp_on = 1'b0;
        frame_n = 1'b1;
        wait_clk(10);
        if (m_cnt >= 16) begin
            case (m_sr[15:14])
                2'b00: begin m_dac = m_sr[13:2]; m_upd++; end
                2'b01: begin m_en = 1'b0; m_sdo = 1'b0; end
                2'b11: m_rise = 1'b1;
                default: ;
            endcase
        end
        // R3: one cycle of pulse per write
        chk(upd_seen == m_upd, "R3 pulse count", upd_seen, m_upd);
        cmp_on = 1'b1;
        wait_clk(6);
    endtask

    task automatic do_reset();
        cmp_on = 1'b0;
        rst_n = 1'b0;
        frame_n = 1'b1;
        ser_clk = 1'b0;
        ser_in = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        m_sr = '0; m_dac = '0; m_rise = 1'b0; m_en = 1'b1; m_sdo = 1'b0;
        m_cnt = 0; upd_seen = 0; m_upd = 0;
        wait_clk(5);
        chk(dac_code == 12'h0, "R1 code", int'(dac_code), 0);
        chk(dac_upd == 1'b0, "R1 upd", int'(dac_upd), 0);
        chk(ser_out == 1'b0, "R1 ser_out", int'(ser_out), 0);
        chk(rise_mode == 1'b0, "R1 rise_mode", int'(rise_mode), 0);
        chk(sdo_en == 1'b1, "R1 sdo_en", int'(sdo_en), 1);
        cmp_on = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: load with pad bits set (ignored)
        send({48'h0, 2'b00, 12'hA5C, 2'b11}, 16);
        chk(dac_code == 12'hA5C, "R2 load A5C", int'(dac_code), 'hA5C);
        send({48'h0, 2'b00, 12'hFFF, 2'b00}, 16);
        chk(dac_code == 12'hFFF, "R2 load FFF", int'(dac_code), 'hFFF);
        // R5: short frame discarded
        send({54'h0, 10'b0000000001}, 10);
        chk(dac_code == 12'hFFF, "R5 short frame", int'(dac_code), 'hFFF);
        // R6: no-op frame
        send({48'h0, 2'b10, 12'h123, 2'b00}, 16);
        chk(dac_code == 12'hFFF, "R6 nop", int'(dac_code), 'hFFF);
        // R10: serial clocks with frame high
        ser_in = 1'b1;
        for (int k = 0; k < 6; k++) toggle_sclk();
        chk(ser_out == m_sdo, "R10 idle clocks", int'(ser_out), int'(m_sdo));
        // R9: two-device chain frame, 32 clocks
        send({32'h0, 2'b00, 12'h3C3, 2'b00, 2'b00, 12'h081, 2'b01}, 32);
        chk(dac_code == 12'h081, "R9 chain keeps last word", int'(dac_code), 'h081);
        // R7: switch capture to rising edge, no write
        send({48'h0, 2'b11, 12'h555, 2'b00}, 16);
        chk(rise_mode == 1'b1, "R7 rise set", int'(rise_mode), 1);
        chk(dac_code == 12'h081, "R7 no write", int'(dac_code), 'h081);
        send({48'h0, 2'b00, 12'h6B2, 2'b10}, 16);
        chk(dac_code == 12'h6B2, "R7 rising capture", int'(dac_code), 'h6B2);
        // R8: disable chain output, then chain traffic
        send({48'h0, 2'b01, 12'h7FF, 2'b00}, 16);
        chk(sdo_en == 1'b0, "R8 disabled", int'(sdo_en), 0);
        send({32'h0, 2'b00, 12'hFFF, 2'b11, 2'b00, 12'h19E, 2'b00}, 32);
        chk(ser_out == 1'b0, "R8 held low", int'(ser_out), 0);
        chk(dac_code == 12'h19E, "R8 load still works", int'(dac_code), 'h19E);
        // R1 R7 R8: reset restores defaults
        do_reset();
        send({48'h0, 2'b00, 12'h801, 2'b00}, 16);
        chk(dac_code == 12'h801, "R2 load after reset", int'(dac_code), 'h801);
        send({40'h0, 8'hFF, 2'b00, 12'h010, 2'b00}, 24);
        chk(dac_code == 12'h010, "R9 24-clock frame", int'(dac_code), 'h010);
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule